// File: doc/BRIEF.md
# Blanked Zero-Crossing Phase Detector

This block closes the digital side of a lamp-power phase loop. Each switching period it times how long the load current takes to cross zero after the low-side gate drive turns on. It then sets that delay against a target delay and emits a short corrective pulse toward the oscillator integrator. The target delay arrives as a tick count from the dimming interface. A larger target means more phase lag, and so lower lamp power.

Switching noise right after the low-side device turns on would give false crossings. For this reason a fixed blanking window, counted in clock cycles from the low-side rising edge, masks the comparator flag. The first crossing seen after the window sets the period's measurement. If the drive turns off with no crossing seen, the period yields nothing.

While dim mode is off the block stays idle and all its outputs are low. In dim mode the integrator drifts slowly toward lower frequency on its own. The up pulses raise the frequency and the down pulses lower it.

Top module: `zc_phase_detector`

## Requirements
- R1: Tick 0 is the first clock cycle in which `lo` is sampled high after being low. A `zc` level in ticks 0 to BLANK_CYC-1 is ignored. With the default of 100 cycles at 250 MHz this is 400 ns.
- R2: `meas_phase` reports the tick of the first cycle, at or after BLANK_CYC, in which `zc` is sampled high while `lo` is high. Later `zc` activity in the same on-time is ignored.
- R3: A crossing that arrives after the tick counter reaches 2**CNT_W-1 is reported as 2**CNT_W-1.
- R4: `meas_valid` is high for exactly one cycle: the cycle after the first cycle in which `lo` is sampled low, and only when a crossing was captured. `meas_phase` changes only with that strobe.
- R5: An on-time with no accepted crossing gives no `meas_valid` and no nudge pulse.
- R6: `ref_phase` is sampled in the cycle in which `lo` is first seen low. A measured phase below `ref_phase` gives an up pulse and one above it gives a down pulse. Equal values give no pulse. `nudge_up` and `nudge_dn` are never high together.
- R7: A nudge pulse starts in the same cycle as `meas_valid` and lasts exactly PULSE_CYC cycles (default 4).
- R8: While `dim_en` is low, all outputs are low from the next cycle onward. Any measurement in progress is discarded. After enabling, timing starts only at a new `lo` rising edge.
- R9: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dim_en | input | 1 | Dim-mode enable; the block is idle while low |
| lo | input | 1 | Low-side gate drive, synchronous to clk |
| zc | input | 1 | Zero-crossing comparator flag, synchronised, level |
| ref_phase | input | CNT_W | Target crossing delay in clock ticks |
| nudge_up | output | 1 | Pulse raising the oscillator frequency |
| nudge_dn | output | 1 | Pulse lowering the oscillator frequency |
| meas_phase | output | CNT_W | Last measured crossing delay in ticks |
| meas_valid | output | 1 | One-cycle strobe marking a new measurement |

## Verification
A tick counter that is off by one would show at the ports as a `meas_phase` one away from the tick the bench drove `zc` in. A wrong blanking compare would either accept tick BLANK_CYC-1 or drop tick BLANK_CYC. Both errors appear in the cycle after `lo` falls. A capture flag that is never set, or never cleared, would make later crossings overwrite the first one, or make a period with no crossing still strobe. A stuck pulse counter or a swapped comparison would show as a wrong pulse length or wrong direction within PULSE_CYC+1 cycles of the strobe. An enable that is ignored would let a strobe or pulse through after `dim_en` drops.

// File: rtl/zcpd_pkg.sv
package zcpd_pkg;
   typedef enum logic [1:0] {
      NUDGE_NONE = 2'd0,
      NUDGE_UP   = 2'd1,
      NUDGE_DN   = 2'd2
   } nudge_e;
endpackage

// File: rtl/zcpd_window.sv
module zcpd_window #(
   parameter int CNT_W     = 10,
   parameter int BLANK_CYC = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             lo,
   output logic             fall,
   output logic             open_win,
   output logic [CNT_W-1:0] tick
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] BLANK_T = CNT_W'(BLANK_CYC);

   logic             lo_q;
   logic             running;
   logic [CNT_W-1:0] cnt;
   logic             rise;

   assign rise     = en & lo & ~lo_q;
   assign fall     = en & running & ~lo;
   assign tick     = rise ? '0 : cnt;
   assign open_win = en & lo & (rise | running) & (tick >= BLANK_T);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q    <= 1'b0;
         running <= 1'b0;
         cnt     <= '0;
      end else begin
         lo_q <= lo;
         if (!en) begin
            running <= 1'b0;
            cnt     <= '0;
         end else if (rise) begin
            running <= 1'b1;
            cnt     <= CNT_W'(1);
         end else if (fall) begin
            running <= 1'b0;
         end else if (running && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R1: the window is never open on the first cycle of an on-time
   p_blank_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && lo && !lo_q) |-> !open_win);
endmodule

// File: rtl/zcpd_capture.sv
module zcpd_capture #(
   parameter int CNT_W     = 10,
   parameter int BLANK_CYC = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             open_win,
   input  logic             zc,
   input  logic             fall,
   input  logic [CNT_W-1:0] tick,
   output logic             done,
   output logic [CNT_W-1:0] cap,
   output logic [CNT_W-1:0] meas_phase,
   output logic             meas_valid
);
   logic got;

   assign done = fall & got;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         got        <= 1'b0;
         cap        <= '0;
         meas_phase <= '0;
         meas_valid <= 1'b0;
      end else if (!en) begin
         got        <= 1'b0;
         meas_phase <= '0;
         meas_valid <= 1'b0;
      end else begin
         meas_valid <= done;
         if (done) meas_phase <= cap;
         if (fall) begin
            got <= 1'b0;
         end else if (open_win && zc && !got) begin
            got <= 1'b1;
            cap <= tick;
         end
      end
   end

   // R4: the strobe lasts one cycle
   p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |=> !meas_valid);
   // R4: the strobe follows the end of an on-time
   p_valid_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |-> $past(fall));
   // R2: a reported phase is never inside the blanking window
   p_meas_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |-> (meas_phase >= CNT_W'(BLANK_CYC)));
endmodule

// File: rtl/zcpd_nudge.sv
module zcpd_nudge
   import zcpd_pkg::*;
#(
   parameter int CNT_W     = 10,
   parameter int PULSE_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             done,
   input  logic [CNT_W-1:0] cap,
   input  logic [CNT_W-1:0] ref_phase,
   output logic             up,
   output logic             dn
);
   nudge_e dir;

   always_comb begin
      if (cap < ref_phase)      dir = NUDGE_UP;
      else if (cap > ref_phase) dir = NUDGE_DN;
      else                      dir = NUDGE_NONE;
   end

   generate
      if (PULSE_CYC == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               up <= 1'b0;
               dn <= 1'b0;
            end else begin
               up <= en & done & (dir == NUDGE_UP);
               dn <= en & done & (dir == NUDGE_DN);
            end
         end
      end else begin : g_count
         localparam int PW_W = $clog2(PULSE_CYC);
         localparam logic [PW_W-1:0] PW_LOAD = PW_W'(PULSE_CYC - 1);
         logic [PW_W-1:0] rem;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               up  <= 1'b0;
               dn  <= 1'b0;
               rem <= '0;
            end else if (!en) begin
               up  <= 1'b0;
               dn  <= 1'b0;
               rem <= '0;
            end else if (done) begin
               up  <= (dir == NUDGE_UP);
               dn  <= (dir == NUDGE_DN);
               rem <= (dir == NUDGE_NONE) ? '0 : PW_LOAD;
            end else if (rem != '0) begin
               rem <= rem - 1'b1;
            end else begin
               up <= 1'b0;
               dn <= 1'b0;
            end
         end
      end
   endgenerate

   // R6: never both directions
   p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(up && dn));
   // R7: a pulse only begins on a finished measurement
   p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(up) || $rose(dn)) |-> $past(done));
endmodule

// File: rtl/zc_phase_detector.sv
module zc_phase_detector #(
   parameter int CNT_W     = 10,
   parameter int BLANK_CYC = 100,
   parameter int PULSE_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dim_en,
   input  logic             lo,
   input  logic             zc,
   input  logic [CNT_W-1:0] ref_phase,
   output logic             nudge_up,
   output logic             nudge_dn,
   output logic [CNT_W-1:0] meas_phase,
   output logic             meas_valid
);
   generate
      if (CNT_W < 2 || CNT_W > 20) begin : g_bad_w
         $error("CNT_W out of range");
      end
      if (BLANK_CYC < 1 || BLANK_CYC >= (1 << CNT_W) - 1) begin : g_bad_b
         $error("BLANK_CYC must fit below the counter limit");
      end
      if (PULSE_CYC < 1 || PULSE_CYC > 256) begin : g_bad_p
         $error("PULSE_CYC out of range");
      end
   endgenerate

   logic             fall;
   logic             open_win;
   logic [CNT_W-1:0] tick;
   logic             done;
   logic [CNT_W-1:0] cap;

   zcpd_window #(.CNT_W(CNT_W), .BLANK_CYC(BLANK_CYC)) u_win (
      .clk(clk), .rst_n(rst_n), .en(dim_en), .lo(lo),
      .fall(fall), .open_win(open_win), .tick(tick));

   zcpd_capture #(.CNT_W(CNT_W), .BLANK_CYC(BLANK_CYC)) u_cap (
      .clk(clk), .rst_n(rst_n), .en(dim_en), .open_win(open_win), .zc(zc),
      .fall(fall), .tick(tick), .done(done), .cap(cap),
      .meas_phase(meas_phase), .meas_valid(meas_valid));

   zcpd_nudge #(.CNT_W(CNT_W), .PULSE_CYC(PULSE_CYC)) u_ndg (
      .clk(clk), .rst_n(rst_n), .en(dim_en), .done(done), .cap(cap),
      .ref_phase(ref_phase), .up(nudge_up), .dn(nudge_dn));

   // R8: idle outputs while dim mode is off
   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !dim_en |=> (!nudge_up && !nudge_dn && !meas_valid));
   // R7: a pulse starts together with the strobe
   p_pulse_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(nudge_up) || $rose(nudge_dn)) |-> meas_valid);
endmodule

// File: tb/tb_zc_phase_detector.sv
module tb_zc_phase_detector;
   localparam int CNT_W = 10;
   localparam int BLANK = 100;
   localparam int PW    = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             dim_en = 1'b0;
   logic             lo = 1'b0;
   logic             zc = 1'b0;
   logic [CNT_W-1:0] ref_phase = '0;
   logic             nudge_up, nudge_dn, meas_valid;
   logic [CNT_W-1:0] meas_phase;

   int checks = 0;
   int failures = 0;
   int v_len, up_len, dn_len, both;
   int first_phase;
   logic first_up, first_dn;

   always #2 clk = ~clk;

   zc_phase_detector #(.CNT_W(CNT_W), .BLANK_CYC(BLANK), .PULSE_CYC(PW)) dut (
      .clk(clk), .rst_n(rst_n), .dim_en(dim_en), .lo(lo), .zc(zc),
      .ref_phase(ref_phase), .nudge_up(nudge_up), .nudge_dn(nudge_dn),
      .meas_phase(meas_phase), .meas_valid(meas_valid));

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one on-time: zc high on ticks [a0,a1] and [b0,b1]; dim_en dropped at tick kill (-1 none)
   task automatic period(int on_len, int a0, int a1, int b0, int b1, int refv, int kill);
      for (int i = 0; i < on_len; i++) begin
         lo = 1'b1;
         zc = ((i >= a0 && i <= a1) || (i >= b0 && i <= b1));
         if (i == kill) dim_en = 1'b0;
         @(negedge clk);
      end
      lo = 1'b0; zc = 1'b0; ref_phase = CNT_W'(refv);
      @(negedge clk);
      first_phase = meas_phase;
      first_up = nudge_up;
      first_dn = nudge_dn;
      v_len = meas_valid; up_len = nudge_up; dn_len = nudge_dn;
      both = nudge_up & nudge_dn;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         v_len += meas_valid; up_len += nudge_up; dn_len += nudge_dn;
         both += nudge_up & nudge_dn;
      end
      dim_en = 1'b1;
   endtask

   task automatic t_reset();
      check("R9 up", nudge_up, 0);
      check("R9 dn", nudge_dn, 0);
      check("R9 valid", meas_valid, 0);
      check("R9 phase", meas_phase, 0);
   endtask

   task automatic t_blank_only();
      period(200, 10, BLANK - 1, -1, -1, 500, -1);
      check("R1 blanked valid", v_len, 0);
      check("R5 no pulse", up_len + dn_len, 0);
   endtask

   task automatic t_blank_edge();
      period(200, BLANK - 1, BLANK - 1, 130, 131, 500, -1);
      check("R1 tick BLANK-1 ignored", first_phase, 130);
      period(200, BLANK, BLANK, -1, -1, 500, -1);
      check("R2 tick BLANK accepted", first_phase, BLANK);
      check("R4 one strobe", v_len, 1);
   endtask

   task automatic t_level_held();
      period(200, 40, 190, -1, -1, 500, -1);
      check("R2 held level", first_phase, BLANK);
   endtask

   task automatic t_first_wins();
      period(300, 120, 121, 200, 210, 500, -1);
      check("R2 first crossing", first_phase, 120);
   endtask

   task automatic t_up();
      period(300, 150, 150, -1, -1, 200, -1);
      check("R6 up dir", first_up, 1);
      check("R7 up width", up_len, PW);
      check("R6 no dn", dn_len, 0);
   endtask

   task automatic t_dn();
      period(300, 250, 252, -1, -1, 200, -1);
      check("R6 dn dir", first_dn, 1);
      check("R7 dn width", dn_len, PW);
      check("R6 no up", up_len, 0);
      check("R6 never both", both, 0);
   endtask

   task automatic t_equal();
      period(300, 200, 200, -1, -1, 200, -1);
      check("R6 equal no pulse", up_len + dn_len, 0);
      check("R4 equal valid", v_len, 1);
      check("R4 equal phase", first_phase, 200);
   endtask

   task automatic t_none();
      period(250, -1, -1, -1, -1, 500, -1);
      check("R5 no crossing valid", v_len, 0);
      check("R5 no crossing pulse", up_len + dn_len, 0);
      check("R4 phase held", meas_phase, 200);
   endtask

   task automatic t_sat();
      period(1100, 1050, 1052, -1, -1, 0, -1);
      check("R3 saturated", first_phase, 1023);
      check("R6 dn at sat", dn_len, PW);
   endtask

   task automatic t_disable();
      dim_en = 1'b0;
      period(250, 150, 152, -1, -1, 500, -1);
      check("R8 disabled valid", v_len, 0);
      check("R8 disabled pulse", up_len + dn_len, 0);
      period(250, 150, 152, -1, -1, 500, 180);
      check("R8 killed mid on-time", v_len, 0);
      check("R8 killed phase low", meas_phase, 0);
      // enabled while lo already high: no rise, no measurement
      dim_en = 1'b0;
      for (int i = 0; i < 10; i++) begin lo = 1'b1; @(negedge clk); end
      dim_en = 1'b1;
      period(200, 150, 152, -1, -1, 500, -1);
      check("R8 needs new rise", v_len, 0);
      period(200, 150, 152, -1, -1, 500, -1);
      check("R8 resumes", first_phase, 150);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      dim_en = 1'b1;
      repeat (3) @(negedge clk);
      t_blank_only();
      t_blank_edge();
      t_level_held();
      t_first_wins();
      t_up();
      t_dn();
      t_equal();
      t_none();
      t_sat();
      t_disable();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule